// File: doc/BRIEF.md
# Serial Link Bring-Up and Fault Recovery Controller

This block is the control state machine for one end of a point-to-point serial link. It holds the transmitter and receiver in reset, brings them out in a fixed order, and walks the link through a handshake. First both sides wait quietly. Then the transmitter sends idle (NULL) characters. Then it starts sending flow-control tokens (FCT). Normal traffic follows. Any fault reported by the receiver sends the machine back to the start of that sequence.

The receiver reports character events (NULL, FCT, data, time code) and error events (disconnect, parity, escape, credit) as single-cycle pulses. The host asks for the link to come up with an enable or start request, and drops it with a disable request. A sticky flag remembers that a NULL has arrived since the last reset. While the machine is waiting, that flag decides whether a stray character or a parity or escape error counts as a fault. A dwell counter times the reset state, the wait state and the handshake timeouts. All of these times derive from one parameter, `RST_CYCLES`.

Top module: `link_bringup_ctl`

## Requirements
- R1: During and right after reset, `state_o` reads 0 (hold-reset). The state codes are: 0 hold-reset, 1 settle, 2 idle-ready, 3 null-phase, 4 token-phase, 5 active. In state 0, `tx_rst` = 1 and `rx_rst` = 1, and `rx_en` and all three transmit enables are 0.
- R2: Without faults, hold-reset lasts exactly `RST_CYCLES` cycles and then moves to settle. Settle lasts exactly 2*`RST_CYCLES` cycles and then moves to idle-ready.
- R3: The outputs are a decode of the current state. `rx_rst` is 1 only in hold-reset, and `rx_en` is 1 in every other state. `tx_rst` is 1 in states 0 to 2. `tx_null_en` is 1 in states 3 to 5. `tx_fct_en` is 1 in states 4 and 5. `tx_data_en` is 1 only in state 5.
- R4: In settle or idle-ready, a disconnect pulse moves the machine to hold-reset on the next edge. While no NULL has been seen, FCT, data, time-code, parity and escape pulses are ignored, and the state does not change.
- R5: The NULL-seen flag is set by a NULL pulse in any state except hold-reset. It is cleared whenever the machine is in, or is entering, hold-reset. Once it is set, a parity, escape, FCT, data or time-code pulse in settle or idle-ready moves the machine to hold-reset.
- R6: Idle-ready moves to null-phase when (`host_enable` or `host_start`) is 1 and `host_disable` is 0. Otherwise it stays in idle-ready.
- R7: Null-phase moves to token-phase on a NULL pulse. Token-phase moves to active on an FCT pulse.
- R8: If the required event does not arrive within 2*`RST_CYCLES` cycles of entering null-phase or token-phase, the machine returns to hold-reset.
- R9: In null-phase, token-phase and active, a disconnect, parity, escape or credit error, or `host_disable`, moves the machine to hold-reset on the next edge. This takes priority over any progress event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_enable | input | 1 | Host allows the link to come up |
| host_start | input | 1 | Host requests start-up |
| host_disable | input | 1 | Host takes the link down |
| rx_got_null | input | 1 | Receiver saw a NULL (pulse) |
| rx_got_fct | input | 1 | Receiver saw an FCT (pulse) |
| rx_got_data | input | 1 | Receiver saw a data or end character (pulse) |
| rx_got_time | input | 1 | Receiver saw a time code (pulse) |
| rx_err_disc | input | 1 | Disconnect detected |
| rx_err_par | input | 1 | Parity error |
| rx_err_esc | input | 1 | Escape sequence error |
| rx_err_credit | input | 1 | Credit error |
| tx_rst | output | 1 | Hold transmitter in reset |
| rx_rst | output | 1 | Hold receiver in reset |
| rx_en | output | 1 | Receiver enabled |
| tx_null_en | output | 1 | Transmitter may send NULLs |
| tx_fct_en | output | 1 | Transmitter may send FCTs |
| tx_data_en | output | 1 | Transmitter may send data |
| state_o | output | 3 | Current state code (see R1) |

## Verification
Every input is sampled on a rising edge. The state register moves on that edge, and the outputs decode from the state register, so every effect of a stimulus shows one cycle after the stimulus is applied. The bench drives inputs just after a falling edge. A cycle-stepped reference model updates on the rising edge, and the bench compares the design against it on the next falling edge, which is exactly the cycle in which the response is due. Dwell lengths are checked by counting cycles in the model from the cycle the state is entered. The first cycle of a state counts as dwell cycle zero.

// File: rtl/link_bringup_pkg.sv
package link_bringup_pkg;

  typedef enum logic [2:0] {
    LS_HOLD    = 3'd0,
    LS_SETTLE  = 3'd1,
    LS_READY   = 3'd2,
    LS_NULLPH  = 3'd3,
    LS_TOKENPH = 3'd4,
    LS_ACTIVE  = 3'd5
  } link_state_e;

  typedef struct packed {
    logic nul;
    logic fct;
    logic dat;
    logic tcode;
    logic disc;
    logic par;
    logic esc;
    logic credit;
  } rx_evt_t;

  // any error that ends an active handshake or run
  function automatic logic hard_fault(rx_evt_t ev);
    return ev.disc | ev.par | ev.esc | ev.credit;
  endfunction

  // fault rule while settling or ready: gated by NULL-seen flag
  function automatic logic wait_fault(rx_evt_t ev, logic seen);
    return ev.disc | (seen & (ev.par | ev.esc | ev.fct | ev.dat | ev.tcode));
  endfunction

  function automatic int dwell_limit(link_state_e st, int base);
    case (st)
      LS_HOLD:   return base;
      LS_SETTLE: return 2 * base;
      default:   return 2 * base;
    endcase
  endfunction

endpackage

// File: rtl/link_dwell_timer.sv
module link_dwell_timer
  import link_bringup_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int CW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  link_state_e st,
  input  logic        restart,
  output logic        hold_done,
  output logic        settle_done,
  output logic        tmo_hit
);
  localparam int MAXC = 2 * RST_CYCLES;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (restart)                cnt <= '0;
    else if (cnt != CW'(MAXC))       cnt <= cnt + 1'b1;
  end

  assign hold_done   = (cnt == CW'(dwell_limit(LS_HOLD, RST_CYCLES) - 1));
  assign settle_done = (cnt == CW'(dwell_limit(LS_SETTLE, RST_CYCLES) - 1));
  assign tmo_hit     = (cnt == CW'(dwell_limit(LS_NULLPH, RST_CYCLES) - 1));

  // R2
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_HOLD) |-> (cnt < CW'(RST_CYCLES)));

  // R8
  tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_NULLPH || st == LS_TOKENPH) |-> (cnt < CW'(MAXC)));

endmodule

// File: rtl/link_null_flag.sv
module link_null_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic set,
  output logic seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen <= 1'b0;
    else if (clear) seen <= 1'b0;
    else if (set)   seen <= 1'b1;
  end

  // R5
  seen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !seen);

endmodule

// File: rtl/link_next_state.sv
module link_next_state
  import link_bringup_pkg::*;
(
  input  link_state_e st,
  input  rx_evt_t     ev,
  input  logic        seen,
  input  logic        go_req,
  input  logic        down_req,
  input  logic        hold_done,
  input  logic        settle_done,
  input  logic        tmo_hit,
  output link_state_e nxt
);
  always_comb begin
    nxt = st;
    case (st)
      LS_HOLD:    if (hold_done) nxt = LS_SETTLE;
      LS_SETTLE: begin
        if (wait_fault(ev, seen)) nxt = LS_HOLD;
        else if (settle_done)     nxt = LS_READY;
      end
      LS_READY: begin
        if (wait_fault(ev, seen))     nxt = LS_HOLD;
        else if (go_req && !down_req) nxt = LS_NULLPH;
      end
      LS_NULLPH: begin
        if (hard_fault(ev) || down_req) nxt = LS_HOLD;
        else if (ev.nul)                nxt = LS_TOKENPH;
        else if (tmo_hit)               nxt = LS_HOLD;
      end
      LS_TOKENPH: begin
        if (hard_fault(ev) || down_req) nxt = LS_HOLD;
        else if (ev.fct)                nxt = LS_ACTIVE;
        else if (tmo_hit)               nxt = LS_HOLD;
      end
      LS_ACTIVE:  if (hard_fault(ev) || down_req) nxt = LS_HOLD;
      default:    nxt = LS_HOLD;
    endcase
  end
endmodule

// File: rtl/link_bringup_ctl.sv
module link_bringup_ctl
  import link_bringup_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_enable,
  input  logic       host_start,
  input  logic       host_disable,
  input  logic       rx_got_null,
  input  logic       rx_got_fct,
  input  logic       rx_got_data,
  input  logic       rx_got_time,
  input  logic       rx_err_disc,
  input  logic       rx_err_par,
  input  logic       rx_err_esc,
  input  logic       rx_err_credit,
  output logic       tx_rst,
  output logic       rx_rst,
  output logic       rx_en,
  output logic       tx_null_en,
  output logic       tx_fct_en,
  output logic       tx_data_en,
  output logic [2:0] state_o
);
  localparam int CW = $clog2(2 * RST_CYCLES + 1);

  link_state_e st, nxt;
  rx_evt_t     ev;
  logic        seen, hold_done, settle_done, tmo_hit;
  logic        restart, flag_clear;

  assign ev = '{nul: rx_got_null, fct: rx_got_fct, dat: rx_got_data,
                tcode: rx_got_time, disc: rx_err_disc, par: rx_err_par,
                esc: rx_err_esc, credit: rx_err_credit};

  assign restart    = (nxt != st);
  assign flag_clear = (st == LS_HOLD) || (nxt == LS_HOLD);

  link_dwell_timer #(.RST_CYCLES(RST_CYCLES), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .st(st), .restart(restart),
    .hold_done(hold_done), .settle_done(settle_done), .tmo_hit(tmo_hit));

  link_null_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clear(flag_clear), .set(rx_got_null),
    .seen(seen));

  link_next_state u_next (
    .st(st), .ev(ev), .seen(seen), .go_req(host_enable | host_start),
    .down_req(host_disable), .hold_done(hold_done),
    .settle_done(settle_done), .tmo_hit(tmo_hit), .nxt(nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= LS_HOLD;
    else        st <= nxt;
  end

  assign rx_rst     = (st == LS_HOLD);
  assign rx_en      = (st != LS_HOLD);
  assign tx_rst     = (st == LS_HOLD) || (st == LS_SETTLE) || (st == LS_READY);
  assign tx_null_en = (st == LS_NULLPH) || (st == LS_TOKENPH) || (st == LS_ACTIVE);
  assign tx_fct_en  = (st == LS_TOKENPH) || (st == LS_ACTIVE);
  assign tx_data_en = (st == LS_ACTIVE);
  assign state_o    = st;

  // R9
  active_fault_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_ACTIVE && (hard_fault(ev) || host_disable)) |=> (st == LS_HOLD));

  // R7
  token_to_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_TOKENPH && rx_got_fct && !hard_fault(ev) && !host_disable)
      |=> (st == LS_ACTIVE));

  // R3
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_null_en) |-> ($past(st) == LS_READY));

  // R4
  wait_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == LS_SETTLE || st == LS_READY) && rx_err_disc) |=> (st == LS_HOLD));

endmodule

// File: tb/link_bringup_ctl_bench.sv
module link_bringup_ctl_bench;
  localparam int RC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_en = 0, h_st = 0, h_dis = 0;
  logic e_nul = 0, e_fct = 0, e_dat = 0, e_tim = 0;
  logic e_disc = 0, e_par = 0, e_esc = 0, e_cred = 0;
  logic tx_rst, rx_rst, rx_en, tx_null_en, tx_fct_en, tx_data_en;
  logic [2:0] state_o;

  int errors = 0;
  int checks = 0;

  int    ms = 0;
  int    mcnt = 0;
  bit    mseen = 0;
  string mtag = "R1";

  always #2 clk = ~clk;

  link_bringup_ctl #(.RST_CYCLES(RC)) u_link_bringup_ctl (
    .clk(clk), .rst_n(rst_n), .host_enable(h_en), .host_start(h_st),
    .host_disable(h_dis), .rx_got_null(e_nul), .rx_got_fct(e_fct),
    .rx_got_data(e_dat), .rx_got_time(e_tim), .rx_err_disc(e_disc),
    .rx_err_par(e_par), .rx_err_esc(e_esc), .rx_err_credit(e_cred),
    .tx_rst(tx_rst), .rx_rst(rx_rst), .rx_en(rx_en), .tx_null_en(tx_null_en),
    .tx_fct_en(tx_fct_en), .tx_data_en(tx_data_en), .state_o(state_o));

  // expected output vector {tx_rst,rx_rst,rx_en,null,fct,data} per state (R3)
  function automatic logic [5:0] exp_outs(int s);
    logic [5:0] v;
    v[5] = (s <= 2);
    v[4] = (s == 0);
    v[3] = (s != 0);
    v[2] = (s >= 3);
    v[1] = (s >= 4);
    v[0] = (s == 5);
    return v;
  endfunction

  // reference model, one step per rising edge
  always @(posedge clk) begin
    int  n;
    bit  anyerr, waiterr;
    if (rst_n) begin
      n = ms;
      anyerr  = e_disc | e_par | e_esc | e_cred | h_dis;
      waiterr = e_disc | (mseen & (e_par | e_esc | e_fct | e_dat | e_tim));
      case (ms)
        0: if (mcnt == RC - 1) begin n = 1; mtag = "R2"; end
        1: if (waiterr) begin n = 0; mtag = e_disc ? "R4" : "R5"; end
           else if (mcnt == 2 * RC - 1) begin n = 2; mtag = "R2"; end
           else mtag = "R4";
        2: if (waiterr) begin n = 0; mtag = e_disc ? "R4" : "R5"; end
           else if ((h_en | h_st) & !h_dis) begin n = 3; mtag = "R6"; end
           else mtag = "R6";
        3, 4: if (anyerr) begin n = 0; mtag = "R9"; end
           else if ((ms == 3 && e_nul) || (ms == 4 && e_fct)) begin n = ms + 1; mtag = "R7"; end
           else if (mcnt == 2 * RC - 1) begin n = 0; mtag = "R8"; end
           else mtag = "R8";
        default: if (anyerr) begin n = 0; mtag = "R9"; end else mtag = "R9";
      endcase
      if (ms == 0 || n == 0) mseen = 0;
      else if (e_nul) mseen = 1;
      mcnt = (n != ms) ? 0 : mcnt + 1;
      ms = n;
    end
  end

  task automatic compare_now(string tag);
    logic [5:0] got, exp;
    checks++;
    got = {tx_rst, rx_rst, rx_en, tx_null_en, tx_fct_en, tx_data_en};
    exp = exp_outs(ms);
    if (state_o !== 3'(ms) || got !== exp) begin
      errors++;
      $display("FAIL %s: state=%0d outs=%b expected state=%0d outs=%b",
               tag, state_o, got, ms, exp);
    end
  endtask

  task automatic idle_inputs();
    {h_en, h_st, h_dis, e_nul, e_fct, e_dat, e_tim, e_disc, e_par, e_esc, e_cred} = '0;
  endtask

  // advance one cycle, then compare on the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_now(mtag);
    idle_inputs();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_state(int s, string tag);
    checks++;
    if (state_o !== 3'(s)) begin
      errors++;
      $display("FAIL %s: state=%0d expected %0d", tag, state_o, s);
    end
  endtask

  task automatic to_ready();
    while (ms != 2) tick();
  endtask

  task automatic main_seq();
    idle_inputs();
    repeat (3) @(negedge clk);
    compare_now("R1");
    expect_state(0, "R1");
    rst_n = 1'b1;
    ticks(RC - 1);
    expect_state(0, "R2");
    tick();
    expect_state(1, "R2");
    ticks(2 * RC - 1);
    expect_state(1, "R2");
    tick();
    expect_state(2, "R2");
    // stray characters with no NULL seen are ignored
    e_fct = 1; e_par = 1; tick(); expect_state(2, "R4");
    e_dat = 1; e_tim = 1; e_esc = 1; tick(); expect_state(2, "R4");
    // disable wins over enable
    h_en = 1; h_dis = 1; tick(); expect_state(2, "R6");
    h_st = 1; tick(); expect_state(3, "R6");
    e_nul = 1; tick(); expect_state(4, "R7");
    e_fct = 1; tick(); expect_state(5, "R7");
    ticks(5); expect_state(5, "R9");
    e_cred = 1; tick(); expect_state(0, "R9");
    to_ready();
    e_nul = 1; tick(); expect_state(2, "R5");
    e_dat = 1; tick(); expect_state(0, "R5");
    ticks(RC + 3);
    e_nul = 1; tick(); expect_state(1, "R5");
    e_esc = 1; tick(); expect_state(0, "R5");
    to_ready();
    e_disc = 1; tick(); expect_state(0, "R4");
    to_ready();
    h_en = 1; tick(); expect_state(3, "R6");
    ticks(2 * RC - 1); expect_state(3, "R8");
    tick(); expect_state(0, "R8");
    to_ready();
    h_en = 1; tick();
    e_nul = 1; tick(); expect_state(4, "R7");
    ticks(2 * RC - 1); expect_state(4, "R8");
    tick(); expect_state(0, "R8");
    to_ready();
    h_en = 1; tick(); e_nul = 1; tick();
    e_fct = 1; e_par = 1; tick(); expect_state(0, "R9");
    to_ready();
    h_en = 1; tick(); e_nul = 1; tick(); e_fct = 1; tick();
    h_dis = 1; tick(); expect_state(0, "R9");
    // constrained random phase
    void'($urandom(32'h1D5A_7E01));
    for (int i = 0; i < 8000; i++) begin
      h_en   = ($urandom_range(0, 3) != 0);
      h_st   = ($urandom_range(0, 7) == 0);
      h_dis  = ($urandom_range(0, 199) == 0);
      e_nul  = ($urandom_range(0, 5) == 0);
      e_fct  = ($urandom_range(0, 9) == 0);
      e_dat  = ($urandom_range(0, 19) == 0);
      e_tim  = ($urandom_range(0, 39) == 0);
      e_disc = ($urandom_range(0, 299) == 0);
      e_par  = ($urandom_range(0, 199) == 0);
      e_esc  = ($urandom_range(0, 199) == 0);
      e_cred = ($urandom_range(0, 299) == 0);
      tick();
    end
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule